// File: doc/BRIEF.md
# Video Acquisition Window with Field Detection

This block marks out, pixel by pixel, the part of an incoming video raster that a downstream scaler should take in, and tells which field of an interlaced frame is arriving. A rising edge on the horizontal reference starts a line. A selected edge on the vertical reference starts a field. Counting from those edges, the window opens at a programmed offset in source pixels and source lines. It stays open for a programmed source length. It closes early once the scaler reports that it has produced the programmed number of output pixels in the line or output lines in the field.

The field flag is the level of the horizontal reference at the moment of the chosen vertical edge, with an optional inversion. A field flag supplied from inside the chip can be selected in its place. A task controller can use the field flag and a frame-start pulse to schedule work. The block carries no pixel data, so it has no valid/ready handshake and applies no back-pressure. The output strobes (`out_pix_i`, `out_line_i`) are counted whenever they are high. The six window parameters are sampled into shadow registers at each field start. All counters stop at 4095 instead of wrapping.

Top module: `vaw_top`

## Requirements
- R1: After reset `acq_o`, `line_act_o`, `sow_o`, `eow_o`, `fid_o` and `frame_o` are all 0.
- R2: Valid pixels are indexed from 0, starting at the first one after a rising edge of `href_i`. `acq_o` is high for indexes `h_off` to `h_off+h_len-1`, as long as the line is active and the target pixel count has not been reached.
- R3: Within a line, acquisition stops once `h_tgt` cycles with `out_pix_i` high have been counted since the line start, even if source pixels remain.
- R4: The line that begins at the first rising `href_i` edge after the field edge is line 0. `line_act_o` is high for line indexes `v_off` to `v_off+v_len-1`.
- R5: Once `v_tgt` cycles with `out_line_i` high have been counted in a field, `line_act_o` is low for the rest of that field, and `eow_o` gives exactly one pulse.
- R6: If a field edge arrives after the window has acquired a pixel but before the target line count was reached, `eow_o` gives exactly one pulse.
- R7: `sow_o` pulses together with the first acquired pixel of a field and only then.
- R8: At the field edge, `fid_o` takes the level of `href_i` XOR `fid_inv_i`. The field edge is the falling edge of `vref_i` when `vedge_rise_i`=0 and the rising edge when `vedge_rise_i`=1.
- R9: With `fid_int_sel_i`=1, `fid_o` takes `fid_int_i` XOR `fid_inv_i` at the field edge, and `href_i` has no effect on it.
- R10: `frame_o` pulses for one cycle at a field edge whose new field flag is 0 (first field) and does not pulse when the new flag is 1 (second field).
- R11: A change to the window parameters in mid-field takes effect only from the next field edge.
- R12: `acq_o` is never high while `pix_vld_i` is low, and cycles without a valid pixel do not advance the pixel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | A source pixel is present this cycle |
| href_i | input | 1 | Horizontal reference; its rising edge starts a line |
| vref_i | input | 1 | Vertical reference; the selected edge starts a field |
| fid_int_i | input | 1 | Field flag supplied from inside the chip |
| out_pix_i | input | 1 | Scaler produced one output pixel |
| out_line_i | input | 1 | Scaler produced one output line |
| h_off_i | input | 12 | Horizontal offset in source pixels |
| h_len_i | input | 12 | Horizontal source length in pixels |
| h_tgt_i | input | 12 | Target output pixels per line |
| v_off_i | input | 12 | Vertical offset in source lines |
| v_len_i | input | 12 | Vertical source length in lines |
| v_tgt_i | input | 12 | Target output lines per field |
| vedge_rise_i | input | 1 | 0: falling vertical edge, 1: rising vertical edge |
| fid_inv_i | input | 1 | Invert the detected field flag |
| fid_int_sel_i | input | 1 | 1: use `fid_int_i` as the field flag source |
| acq_o | output | 1 | Take this pixel |
| line_act_o | output | 1 | Current line lies inside the window |
| sow_o | output | 1 | First acquired pixel of the field |
| eow_o | output | 1 | Window closed for this field |
| fid_o | output | 1 | Field flag (0 = first field) |
| frame_o | output | 1 | Frame start: field edge that begins a first field |

## Verification
The hardest case to reach is the vertical cut. A field must have acquired at least one pixel and must still be short of its target line count when the next field edge arrives. The bench sets a large target line count, runs two active lines, and then issues a field edge. It checks that exactly one end pulse appears. Telling the two field-edge choices apart is also awkward, because a constant horizontal level gives the same flag for both. The bench therefore changes `href_i` between the rising and falling vertical edges, so each choice of edge yields a different field flag.

// File: rtl/vaw_pkg.sv
package vaw_pkg;
  localparam int unsigned CW_DEF    = 12;
  localparam int unsigned SYNC_DEF  = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } vedge_e;
endpackage

// File: rtl/vaw_sync.sv
module vaw_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    // stages 0..STAGES-1 synchronise, stage STAGES keeps the previous level
    logic [STAGES:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '0;
      else         sh <= {sh[STAGES-1:0], d_i[b]};
    end
    assign q_o[b]    = sh[STAGES-1];
    assign rise_o[b] = sh[STAGES-1] & ~sh[STAGES];
    assign fall_o[b] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/vaw_span.sv
module vaw_span #(
  parameter int CW   = 12,
  parameter int LEAD = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          src_step_i,
  input  logic          tgt_step_i,
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] tsz_i,
  output logic          open_o,
  output logic          done_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam int            SW   = CW + 2;

  logic [CW-1:0] scnt, tcnt;
  logic [SW-1:0] lo, hi, sext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt <= '0;
      tcnt <= '0;
    end else if (clr_i) begin
      scnt <= '0;
      tcnt <= '0;
    end else begin
      if (src_step_i && scnt != CMAX) scnt <= scnt + 1'b1;
      if (tgt_step_i && tcnt != CMAX) tcnt <= tcnt + 1'b1;
    end
  end

  assign lo     = {2'b00, off_i} + SW'(LEAD);
  assign hi     = lo + {2'b00, len_i};
  assign sext   = {2'b00, scnt};
  assign open_o = (sext >= lo) && (sext < hi);
  assign done_o = (tcnt >= tsz_i);
endmodule

// File: rtl/vaw_field.sv
module vaw_field (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vedge_i,
  input  logic href_lvl_i,
  input  logic fid_int_i,
  input  logic sel_int_i,
  input  logic inv_i,
  output logic fid_o,
  output logic frame_o
);
  logic raw_fid;
  assign raw_fid = (sel_int_i ? fid_int_i : href_lvl_i) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fid_o   <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      frame_o <= vedge_i & ~raw_fid;
      if (vedge_i) fid_o <= raw_fid;
    end
  end
endmodule

// File: rtl/vaw_top.sv
module vaw_top #(
  parameter int CW    = vaw_pkg::CW_DEF,
  parameter int SYNCN = vaw_pkg::SYNC_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_vld_i,
  input  logic          href_i,
  input  logic          vref_i,
  input  logic          fid_int_i,
  input  logic          out_pix_i,
  input  logic          out_line_i,
  input  logic [CW-1:0] h_off_i,
  input  logic [CW-1:0] h_len_i,
  input  logic [CW-1:0] h_tgt_i,
  input  logic [CW-1:0] v_off_i,
  input  logic [CW-1:0] v_len_i,
  input  logic [CW-1:0] v_tgt_i,
  input  logic          vedge_rise_i,
  input  logic          fid_inv_i,
  input  logic          fid_int_sel_i,
  output logic          acq_o,
  output logic          line_act_o,
  output logic          sow_o,
  output logic          eow_o,
  output logic          fid_o,
  output logic          frame_o
);
  import vaw_pkg::*;

  logic [1:0] ref_q, ref_rise, ref_fall;
  logic       href_edge, vref_edge;

  vaw_sync #(.N(2), .STAGES(SYNCN)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({vref_i, href_i}),
    .q_o   (ref_q), .rise_o(ref_rise), .fall_o(ref_fall)
  );

  assign href_edge = ref_rise[0];
  assign vref_edge = (vedge_e'(vedge_rise_i) == EDGE_RISE) ? ref_rise[1] : ref_fall[1];

  // shadow copies of the window, refreshed once per field
  logic [CW-1:0] sh_hoff, sh_hlen, sh_htgt, sh_voff, sh_vlen, sh_vtgt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_hoff <= '0; sh_hlen <= '0; sh_htgt <= '0;
      sh_voff <= '0; sh_vlen <= '0; sh_vtgt <= '0;
    end else if (vref_edge) begin
      sh_hoff <= h_off_i; sh_hlen <= h_len_i; sh_htgt <= h_tgt_i;
      sh_voff <= v_off_i; sh_vlen <= v_len_i; sh_vtgt <= v_tgt_i;
    end
  end

  logic h_open, h_done, v_open, v_done;

  vaw_span #(.CW(CW), .LEAD(0)) u_hspan (
    .clk_i     (clk_i),     .rst_ni    (rst_ni),
    .clr_i     (href_edge | vref_edge),
    .src_step_i(pix_vld_i), .tgt_step_i(out_pix_i),
    .off_i     (sh_hoff),   .len_i     (sh_hlen), .tsz_i(sh_htgt),
    .open_o    (h_open),    .done_o    (h_done)
  );

  vaw_span #(.CW(CW), .LEAD(1)) u_vspan (
    .clk_i     (clk_i),     .rst_ni    (rst_ni),
    .clr_i     (vref_edge),
    .src_step_i(href_edge), .tgt_step_i(out_line_i),
    .off_i     (sh_voff),   .len_i     (sh_vlen), .tsz_i(sh_vtgt),
    .open_o    (v_open),    .done_o    (v_done)
  );

  vaw_field u_field (
    .clk_i     (clk_i),     .rst_ni   (rst_ni),
    .vedge_i   (vref_edge), .href_lvl_i(ref_q[0]),
    .fid_int_i (fid_int_i), .sel_int_i(fid_int_sel_i),
    .inv_i     (fid_inv_i), .fid_o    (fid_o),
    .frame_o   (frame_o)
  );

  logic started_q, ended_q, vdone_q, close_hit;

  assign line_act_o = v_open & ~v_done;
  assign acq_o      = pix_vld_i & line_act_o & h_open & ~h_done & ~href_edge & ~vref_edge;
  assign sow_o      = acq_o & ~started_q;
  assign close_hit  = v_done & ~vdone_q & started_q & ~ended_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      ended_q   <= 1'b0;
      vdone_q   <= 1'b0;
      eow_o     <= 1'b0;
    end else begin
      vdone_q <= v_done;
      if (vref_edge) begin
        eow_o     <= started_q & ~ended_q;
        started_q <= 1'b0;
        ended_q   <= 1'b0;
      end else begin
        eow_o <= close_hit;
        if (acq_o)     started_q <= 1'b1;
        if (close_hit) ended_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vaw_chk.sv
module vaw_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pix_vld_i,
  input logic acq_o,
  input logic line_act_o,
  input logic sow_o,
  input logic eow_o,
  input logic fid_o,
  input logic frame_o
);
  a_r12_acq_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_o |-> (pix_vld_i && line_act_o));

  a_r7_sow_with_acq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sow_o |-> acq_o);

  a_r7_sow_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sow_o |=> !sow_o);

  a_r5_eow_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eow_o |=> !eow_o);

  a_r10_frame_first_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !fid_o);

  a_r10_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!acq_o && !line_act_o && !sow_o && !eow_o && !fid_o && !frame_o);
    end
  end
endmodule

bind vaw_top vaw_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_vld_i (pix_vld_i),
  .acq_o     (acq_o),
  .line_act_o(line_act_o),
  .sow_o     (sow_o),
  .eow_o     (eow_o),
  .fid_o     (fid_o),
  .frame_o   (frame_o)
);

// File: tb/sim_vaw_top.sv
module sim_vaw_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pix_vld = 0, href = 0, vref = 0, fid_int = 0, out_pix = 0, out_line = 0;
  logic [11:0] hoff = 0, hlen = 0, htgt = 0, voff = 0, vlen = 0, vtgt = 0;
  logic vrise = 0, finv = 0, fsel = 0;
  logic acq, lact, sow, eow, fid, frm;

  int total = 0, bad = 0, eow_n = 0, frm_n = 0;
  int l_act, a_cnt, a_first, a_last, a_bad, s_cnt;
  int e0, f0, sacc;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaw_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pix_vld_i(pix_vld), .href_i(href), .vref_i(vref),
    .fid_int_i(fid_int), .out_pix_i(out_pix), .out_line_i(out_line),
    .h_off_i(hoff), .h_len_i(hlen), .h_tgt_i(htgt),
    .v_off_i(voff), .v_len_i(vlen), .v_tgt_i(vtgt),
    .vedge_rise_i(vrise), .fid_inv_i(finv), .fid_int_sel_i(fsel),
    .acq_o(acq), .line_act_o(lact), .sow_o(sow), .eow_o(eow), .fid_o(fid), .frame_o(frm)
  );

  always @(negedge clk) begin
    if (rst_ni && eow) eow_n++;
    if (rst_ni && frm) frm_n++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_win(input int xo, xs, xd, yo, ys, yd);
    hoff = 12'(xo); hlen = 12'(xs); htgt = 12'(xd);
    voff = 12'(yo); vlen = 12'(ys); vtgt = 12'(yd);
  endtask

  // href level is h_r around the rising vref edge and h_f around the falling one
  task automatic vsync2(input logic h_r, input logic h_f);
    @(negedge clk); href = h_r;
    repeat (4) @(negedge clk); vref = 1'b1;
    repeat (6) @(negedge clk); href = h_f;
    repeat (4) @(negedge clk); vref = 1'b0;
    repeat (6) @(negedge clk); href = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic vsync(input logic h);
    vsync2(h, h);
  endtask

  task automatic do_line(input int npix, input bit gaps, input bit tgt_pix, input bit end_strobe);
    int vi = 0;
    a_cnt = 0; a_first = -1; a_last = -1; a_bad = 0; s_cnt = 0;
    @(negedge clk); href = 1'b1;
    repeat (4) @(negedge clk); href = 1'b0;
    repeat (3) @(negedge clk);
    #1 l_act = int'(lact);
    for (int i = 0; i < npix; i++) begin
      @(negedge clk);
      pix_vld = gaps ? i[0] : 1'b1;
      out_pix = 1'b0;
      #1;
      if (acq) begin
        if (!pix_vld) a_bad++;
        if (a_first < 0) a_first = vi;
        a_last = vi;
        a_cnt++;
        if (tgt_pix) out_pix = 1'b1;
      end
      if (sow) s_cnt++;
      if (pix_vld) vi++;
    end
    @(negedge clk); pix_vld = 1'b0; out_pix = 1'b0;
    if (end_strobe) begin
      out_line = 1'b1;
      @(negedge clk); out_line = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 acq", int'(acq), 0);
    chk("R1 line_act", int'(lact), 0);
    chk("R1 eow/sow", int'(eow | sow), 0);
    chk("R1 fid/frame", int'(fid | frm), 0);
  endtask

  task automatic t_window();
    set_win(3, 5, 100, 1, 2, 100);
    f0 = frm_n;
    vsync(1'b0);
    chk("R8 fid falling href0", int'(fid), 0);
    chk("R10 frame on first field", frm_n - f0, 1);
    do_line(12, 0, 0, 0); sacc = s_cnt;
    chk("R4 line0 outside", l_act, 0);
    chk("R2 line0 no acq", a_cnt, 0);
    do_line(12, 0, 0, 0); sacc += s_cnt;
    chk("R4 line1 active", l_act, 1);
    chk("R2 count", a_cnt, 5);
    chk("R2 first", a_first, 3);
    chk("R2 last", a_last, 7);
    do_line(12, 0, 0, 0); sacc += s_cnt;
    chk("R4 line2 active", l_act, 1);
    do_line(12, 0, 0, 0); sacc += s_cnt;
    chk("R4 line3 outside", l_act, 0);
    chk("R7 one sow per field", sacc, 1);
  endtask

  task automatic t_htarget();
    set_win(3, 5, 2, 0, 4, 100);
    vsync(1'b0);
    do_line(12, 0, 1, 0);
    chk("R3 count", a_cnt, 2);
    chk("R3 first", a_first, 3);
    chk("R3 last", a_last, 4);
  endtask

  task automatic t_vtarget();
    set_win(0, 4, 100, 0, 5, 2);
    vsync(1'b0);
    e0 = eow_n;
    do_line(6, 0, 0, 1);
    chk("R5 line0 active", l_act, 1);
    do_line(6, 0, 0, 1);
    chk("R5 line1 active", l_act, 1);
    chk("R5 eow once", eow_n - e0, 1);
    do_line(6, 0, 0, 0);
    chk("R5 line2 closed", l_act, 0);
    chk("R5 no acq after close", a_cnt, 0);
  endtask

  task automatic t_cut();
    set_win(0, 4, 100, 0, 5, 100);
    vsync(1'b0);
    e0 = eow_n;
    do_line(6, 0, 0, 1);
    do_line(6, 0, 0, 1);
    chk("R6 no eow before cut", eow_n - e0, 0);
    vsync(1'b0);
    chk("R6 eow on cut", eow_n - e0, 1);
  endtask

  task automatic t_edge_sel();
    vrise = 1'b0; finv = 1'b0;
    vsync2(1'b0, 1'b1);
    chk("R8 falling edge picks later level", int'(fid), 1);
    vrise = 1'b1;
    f0 = frm_n;
    vsync2(1'b0, 1'b1);
    chk("R8 rising edge picks earlier level", int'(fid), 0);
    chk("R10 frame at rising edge", frm_n - f0, 1);
    f0 = frm_n;
    vsync(1'b1);
    chk("R8 rising href1", int'(fid), 1);
    chk("R10 no frame on second field", frm_n - f0, 0);
    finv = 1'b1;
    vsync(1'b1);
    chk("R8 invert", int'(fid), 0);
    vrise = 1'b0;
    vsync(1'b0);
    chk("R8 invert falling", int'(fid), 1);
    finv = 1'b0;
  endtask

  task automatic t_internal();
    fsel = 1'b1; fid_int = 1'b1; finv = 1'b0;
    vsync(1'b0);
    chk("R9 internal 1", int'(fid), 1);
    finv = 1'b1;
    f0 = frm_n;
    vsync(1'b0);
    chk("R9 internal inverted", int'(fid), 0);
    chk("R10 frame internal", frm_n - f0, 1);
    fid_int = 1'b0; finv = 1'b0;
    vsync(1'b1);
    chk("R9 href ignored", int'(fid), 0);
    fsel = 1'b0;
  endtask

  task automatic t_latch();
    set_win(3, 5, 100, 0, 5, 100);
    vsync(1'b0);
    set_win(0, 5, 100, 0, 5, 100);
    do_line(12, 0, 0, 0);
    chk("R11 old offset kept", a_first, 3);
    vsync(1'b0);
    do_line(12, 0, 0, 0);
    chk("R11 new offset applied", a_first, 0);
  endtask

  task automatic t_gaps();
    set_win(2, 3, 100, 0, 5, 100);
    vsync(1'b0);
    do_line(20, 1, 0, 0);
    chk("R12 no acq without valid", a_bad, 0);
    chk("R12 count", a_cnt, 3);
    chk("R12 first valid index", a_first, 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_window();
    t_htarget();
    t_vtarget();
    t_cut();
    t_edge_sel();
    t_internal();
    t_latch();
    t_gaps();
    finish_run();
  end
endmodule